// File: doc/BRIEF.md
# Half-Precision to Single-Precision Widening Converter

This block turns a 16-bit half-precision operand into the equivalent 32-bit single-precision value. A mode bit selects the decoding of the narrow operand. In IEEE mode the all-ones exponent code carries infinity and NaN in the usual way. In alternative mode that code is an ordinary finite exponent, which extends the range to about ±131008. In that mode no special values exist. Every half value fits exactly in single precision, so the block does no rounding.

Subnormal half operands are normalised with a leading-zero count and become normal single values. A status flag reports each one. A signalling NaN in IEEE mode comes out quiet and raises the invalid flag. The result and both flags are registered, and they appear one clock after the operand is presented. The block can sit directly behind an operand read port in a floating-point pipeline stage.

Top module: `hwide_conv`

## Requirements
- R1: While reset is asserted, and on the first output after it, before any operand has been captured, `res_o`, `invalid_o` and `denorm_o` are all zero.
- R2: The block samples `op_i` and `ieee_mode_i` on a rising clock edge. The converted result and both flags for that sample appear on the outputs after that same edge and hold until the next edge.
- R3: A half operand with exponent code 1..30 gives sign unchanged, single exponent = code + 112, and the 10 fraction bits placed in result bits 22:13 with bits 12:0 zero. No flag is raised.
- R4: A half operand with exponent 0 and fraction 0 gives a single zero with the same sign (bit 31). No flag is raised.
- R5: A half operand with exponent 0 and a nonzero fraction gives an exact normal single. Its exponent is 112 minus the count of leading zeros in the 10-bit fraction. Its fraction is the bits below the leading one, left-aligned. `denorm_o` is raised in both modes.
- R6: In IEEE mode (`ieee_mode_i` = 1), exponent code 31 with a zero fraction gives infinity with the same sign: exponent 0xFF and fraction 0.
- R7: In IEEE mode, exponent code 31 with a nonzero fraction gives a NaN. The sign is kept, bit 22 (quiet) is set, and half fraction bits 8:0 land in result bits 21:13. `invalid_o` is raised exactly when half fraction bit 9 is 0, which marks a signalling NaN.
- R8: In alternative mode (`ieee_mode_i` = 0), exponent code 31 is a normal exponent and gives single exponent 143. No output ever has exponent 0xFF, and `invalid_o` is never raised.
- R9: `invalid_o` and `denorm_o` are never high together. `denorm_o` is high only for an operand with exponent 0 and a nonzero fraction.
- R10: For an operand whose exponent code is below 31, the mode bit has no effect on the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 16 | Half-precision operand: sign bit 15, exponent 14:10, fraction 9:0 |
| ieee_mode_i | input | 1 | 1 = IEEE decoding, 0 = alternative decoding |
| res_o | output | 32 | Single-precision result: sign 31, exponent 30:23, fraction 22:0 |
| invalid_o | output | 1 | Signalling NaN operand in IEEE mode |
| denorm_o | output | 1 | Operand was a half subnormal |

## Verification
The bench targets the subnormal edges, from the smallest fraction 0x001 up to 0x3FF. An off-by-one leading-zero count would shift the exponent by one and keep a stale leading one in the fraction. It checks the all-ones exponent in both modes. A design that ignored the mode would return infinity for 0x7C00 in alternative mode, where 2^16 is correct, or would fold 131008 into a NaN. For NaNs it separates the quiet and signalling cases. A missing quiet bit would let a signalling NaN pass through unchanged, and an inverted test would raise invalid on quiet NaNs. Signed zeros and mode-swapped repeats of random operands show whether a sign bit is lost or the mode leaks into ordinary values.

// File: rtl/hwide_pkg.sv
package hwide_pkg;
  localparam int H_EXP_W  = 5;
  localparam int H_FRAC_W = 10;
  localparam int H_BIAS   = 15;
  localparam int S_EXP_W  = 8;
  localparam int S_FRAC_W = 23;
  localparam int S_BIAS   = 127;
  localparam int H_W      = 1 + H_EXP_W + H_FRAC_W;
  localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;
  localparam int LZ_W     = $clog2(H_FRAC_W + 1);
  localparam int PAD_W    = S_FRAC_W - H_FRAC_W;
  localparam int REBIAS   = S_BIAS - H_BIAS;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } hclass_e;

  // exponent code of a normal (or alternative-mode top) operand, rebiased
  function automatic logic [S_EXP_W-1:0] f_rebias(input logic [H_EXP_W-1:0] e);
    return S_EXP_W'(e) + S_EXP_W'(REBIAS);
  endfunction

  // exponent of a normalised subnormal: leading one sits lz places below the top
  function automatic logic [S_EXP_W-1:0] f_sub_exp(input logic [LZ_W-1:0] lz);
    return S_EXP_W'(REBIAS) - S_EXP_W'(lz);
  endfunction

  // left-align a narrow fraction into the wide field, zero filled
  function automatic logic [S_FRAC_W-1:0] f_align(input logic [H_FRAC_W-1:0] f);
    return {f, {PAD_W{1'b0}}};
  endfunction

  // quieted NaN payload: top bit forced, remaining bits kept
  function automatic logic [S_FRAC_W-1:0] f_quiet(input logic [H_FRAC_W-1:0] f);
    return {1'b1, f[H_FRAC_W-2:0], {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/hwide_classify.sv
module hwide_classify
  import hwide_pkg::*;
(
  input  logic [H_EXP_W-1:0]  exp_i,
  input  logic [H_FRAC_W-1:0] frac_i,
  input  logic                ieee_mode_i,
  output hclass_e             cls_o
);
  logic exp_zero, exp_top, frac_zero;
  assign exp_zero  = (exp_i == '0);
  assign exp_top   = (exp_i == '1);
  assign frac_zero = (frac_i == '0);

  always_comb begin
    cls_o = CL_NORM;
    if (exp_zero) begin
      cls_o = frac_zero ? CL_ZERO : CL_SUB;
    end else if (exp_top && ieee_mode_i) begin
      if (frac_zero)                cls_o = CL_INF;
      else if (frac_i[H_FRAC_W-1])  cls_o = CL_QNAN;
      else                          cls_o = CL_SNAN;
    end
  end
endmodule

// File: rtl/hwide_lzc.sv
module hwide_lzc #(
  parameter int W  = 10,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/hwide_pack.sv
module hwide_pack
  import hwide_pkg::*;
(
  input  logic                sign_i,
  input  logic [H_EXP_W-1:0]  exp_i,
  input  logic [H_FRAC_W-1:0] frac_i,
  input  logic [LZ_W-1:0]     lz_i,
  input  hclass_e             cls_i,
  output logic [S_W-1:0]      res_o,
  output logic                invalid_o,
  output logic                denorm_o
);
  logic [H_FRAC_W-1:0] frac_norm;
  logic [LZ_W-1:0]     shamt;

  assign shamt     = lz_i + LZ_W'(1);
  assign frac_norm = frac_i << shamt;

  always_comb begin
    res_o     = {sign_i, {(S_W-1){1'b0}}};
    invalid_o = 1'b0;
    denorm_o  = 1'b0;
    unique case (cls_i)
      CL_ZERO: res_o = {sign_i, {(S_W-1){1'b0}}};
      CL_SUB: begin
        res_o    = {sign_i, f_sub_exp(lz_i), f_align(frac_norm)};
        denorm_o = 1'b1;
      end
      CL_NORM: res_o = {sign_i, f_rebias(exp_i), f_align(frac_i)};
      CL_INF:  res_o = {sign_i, {S_EXP_W{1'b1}}, {S_FRAC_W{1'b0}}};
      CL_QNAN: res_o = {sign_i, {S_EXP_W{1'b1}}, f_quiet(frac_i)};
      CL_SNAN: begin
        res_o     = {sign_i, {S_EXP_W{1'b1}}, f_quiet(frac_i)};
        invalid_o = 1'b1;
      end
      default: res_o = {sign_i, {(S_W-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/hwide_conv.sv
module hwide_conv
  import hwide_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] op_i,
  input  logic        ieee_mode_i,
  output logic [31:0] res_o,
  output logic        invalid_o,
  output logic        denorm_o
);
  logic                op_sign;
  logic [H_EXP_W-1:0]  op_exp;
  logic [H_FRAC_W-1:0] op_frac;
  hclass_e             op_cls;
  logic [LZ_W-1:0]     op_lz;
  logic [S_W-1:0]      res_d;
  logic                invalid_d, denorm_d;

  assign op_sign = op_i[H_W-1];
  assign op_exp  = op_i[H_W-2 -: H_EXP_W];
  assign op_frac = op_i[H_FRAC_W-1:0];

  hwide_classify u_cls (
    .exp_i       (op_exp),
    .frac_i      (op_frac),
    .ieee_mode_i (ieee_mode_i),
    .cls_o       (op_cls)
  );

  hwide_lzc #(.W(H_FRAC_W), .CW(LZ_W)) u_lzc (
    .vec_i (op_frac),
    .cnt_o (op_lz)
  );

  hwide_pack u_pack (
    .sign_i    (op_sign),
    .exp_i     (op_exp),
    .frac_i    (op_frac),
    .lz_i      (op_lz),
    .cls_i     (op_cls),
    .res_o     (res_d),
    .invalid_o (invalid_d),
    .denorm_o  (denorm_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      denorm_o  <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= invalid_d;
      denorm_o  <= denorm_d;
    end
  end
endmodule

// File: rtl/hwide_conv_chk.sv
module hwide_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] op_i,
  input logic        ieee_mode_i,
  input logic [31:0] res_o,
  input logic        invalid_o,
  input logic        denorm_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4: zero in, signed zero out, quiet flags
  p_signed_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(op_i[14:0] == 15'd0)) |->
      (res_o == {$past(op_i[15]), 31'd0} && !invalid_o && !denorm_o));

  // R8: alternative mode never makes a special value
  p_alt_finite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(ieee_mode_i)) |-> (res_o[30:23] != 8'hFF && !invalid_o));

  // R7: invalid only accompanies a quiet NaN result
  p_quiet_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (res_o[30:23] == 8'hFF && res_o[22]));

  // R9: flags mutually exclusive
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({invalid_o, denorm_o}));

  // R5: denorm flag only for a subnormal operand
  p_denorm_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && denorm_o) |-> $past(op_i[14:10] == 5'd0 && op_i[9:0] != 10'd0));

  // R2: the sign of the captured operand reaches the output one edge later
  p_sign_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (res_o[31] == $past(op_i[15])));
endmodule

bind hwide_conv hwide_conv_chk u_hwide_conv_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .ieee_mode_i (ieee_mode_i),
  .res_o       (res_o),
  .invalid_o   (invalid_o),
  .denorm_o    (denorm_o)
);

// File: tb/hwide_conv_bench.sv
module hwide_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_i = '0;
  logic        ieee_mode_i = 1'b1;
  logic [31:0] res_o;
  logic        invalid_o, denorm_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hwide_conv u_hwide_conv (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .ieee_mode_i(ieee_mode_i),
    .res_o(res_o), .invalid_o(invalid_o), .denorm_o(denorm_o)
  );

  // {invalid, denorm, result}, derived by repeated doubling of the significand
  function automatic logic [33:0] model(input logic [15:0] h, input logic ieee);
    logic       s;
    logic [4:0] e;
    logic [9:0] f;
    logic [10:0] m;
    int ex;
    logic den;
    s = h[15]; e = h[14:10]; f = h[9:0]; den = 1'b0;
    if (e == 5'd31 && ieee) begin
      if (f == 10'd0) return {2'b00, s, 8'hFF, 23'd0};
      return {~f[9], 1'b0, s, 8'hFF, 1'b1, f[8:0], 13'd0};
    end
    if (e == 5'd0 && f == 10'd0) return {2'b00, s, 31'd0};
    if (e == 5'd0) begin
      m = {1'b0, f}; ex = -14; den = 1'b1;
      while (!m[10]) begin m = m << 1; ex = ex - 1; end
    end else begin
      m = {1'b1, f}; ex = int'(e) - 15;
    end
    return {1'b0, den, s, 8'(ex + 127), m[9:0], 13'd0};
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual inv=%b den=%b res=%h expected inv=%b den=%b res=%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(input logic [15:0] h, input logic ieee, input string tag);
    @(negedge clk);
    op_i = h; ieee_mode_i = ieee;
    @(negedge clk);
    check(tag, {invalid_o, denorm_o, res_o}, model(h, ieee));
  endtask

  task automatic apply_lit(input logic [15:0] h, input logic ieee,
                           input logic [33:0] exp, input string tag);
    @(negedge clk);
    op_i = h; ieee_mode_i = ieee;
    @(negedge clk);
    check(tag, {invalid_o, denorm_o, res_o}, exp);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    op_i = 16'h3C00;
    repeat (3) @(negedge clk);
    check("R1 reset", {invalid_o, denorm_o, res_o}, 34'd0);
    rst_n = 1'b1;
    check("R1 after release", {invalid_o, denorm_o, res_o}, 34'd0);

    // R2: output after one edge
    apply_lit(16'h3C00, 1'b1, {2'b00, 32'h3F800000}, "R2 R3 one");
    apply_lit(16'hC000, 1'b0, {2'b00, 32'hC0000000}, "R3 minus two");
    apply_lit(16'h7BFF, 1'b1, {2'b00, 32'h477FE000}, "R3 max normal");
    apply_lit(16'h0000, 1'b1, {2'b00, 32'h00000000}, "R4 plus zero");
    apply_lit(16'h8000, 1'b0, {2'b00, 32'h80000000}, "R4 minus zero");
    apply_lit(16'h0001, 1'b1, {2'b01, 32'h33800000}, "R5 min subnormal");
    apply_lit(16'h83FF, 1'b0, {2'b01, 32'hB87FC000}, "R5 max subnormal");
    apply_lit(16'h0200, 1'b1, {2'b01, 32'h38000000}, "R5 top bit subnormal");
    apply_lit(16'h7C00, 1'b1, {2'b00, 32'h7F800000}, "R6 plus inf");
    apply_lit(16'hFC00, 1'b1, {2'b00, 32'hFF800000}, "R6 minus inf");
    apply_lit(16'h7E00, 1'b1, {2'b00, 32'h7FC00000}, "R7 quiet nan");
    apply_lit(16'hFD00, 1'b1, {2'b10, 32'hFFE00000}, "R7 signalling nan");
    apply_lit(16'h7C01, 1'b1, {2'b10, 32'h7FC02000}, "R7 snan low payload");
    apply_lit(16'h7C00, 1'b0, {2'b00, 32'h47800000}, "R8 alt 2^16");
    apply_lit(16'h7FFF, 1'b0, {2'b00, 32'h47FFE000}, "R8 alt max");
    apply_lit(16'hFD00, 1'b0, {2'b00, 32'hC7A00000}, "R8 alt no invalid");

    // R10: the same random finite operand in both modes
    for (int i = 0; i < 200; i++) begin
      logic [15:0] h;
      logic [33:0] r1;
      h = 16'($urandom());
      if (h[14:10] == 5'd31) h[14] = 1'b0;
      apply(h, 1'b1, "R10 ieee side");
      r1 = {invalid_o, denorm_o, res_o};
      apply(h, 1'b0, "R10 alt side");
      check("R10 mode independent", {invalid_o, denorm_o, res_o}, r1);
    end

    // random mix, bias toward edge exponents (R3 R5 R7 R8 R9)
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] h;
      h = 16'($urandom());
      case ($urandom_range(0, 3))
        0: h[14:10] = 5'd0;
        1: h[14:10] = 5'd31;
        default: ;
      endcase
      apply(h, 1'($urandom()), "R3 R5 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule